// File: doc/BRIEF.md
# Hybrid High-Resolution PWM Generator

This block produces a pulse-width modulated waveform whose edges, phase offset and period can all be placed at positions finer than one clock cycle. A coarse counter and comparator places each edge on a whole clock cycle. A fine code then tells an external delay line how many taps to add after that clock edge. The period, the rising-edge position, the falling-edge position and the phase shift are each given as a 16-bit count of whole clocks plus a 6-bit fraction of a clock. The fractional period works by adding one extra clock to some periods, so that the average period matches the setting.

A delay line's tap delay drifts with process, voltage and temperature. To keep the fine resolution steady, a small digital loop counts how many taps span one clock period. The external line reports on each comparison strobe whether the chosen tap count reaches past one clock (late) or falls short of it (early). The loop steps its count by one per comparison. It reports lock once the decisions have alternated for long enough. Each fractional setting is then scaled by this tap count to form the tap code.

Settings are double-buffered and are captured only at the boundary between two periods, so a period never mixes old and new values. A one-cycle marker output shows where each period starts.

Top module: `hrpwm_gen`

## Requirements
- R1: While reset is asserted, `pwm_out`, `cycle_start`, `cal_locked`, `rise_tap` and `fall_tap` are 0, and `taps_per_clk` equals the parameter TAPS_INIT (default 32).
- R2: Let k be the index of a clock within a period, 0 to P-1, where P = `period_int`. With all fractions and the phase at zero, `pwm_out` is high exactly for rise_int <= k < fall_int.
- R3: With a phase setting, the block first forms a shifted index s = (k - phase_int) mod P. It then forms the coarse edge positions as rise_int plus the carry out of (rise_frac + phase_frac), and fall_int plus the carry out of (fall_frac + phase_frac), each sum taken in 6 bits. `pwm_out` is high for rise_pos <= s < fall_pos. This includes waveforms that wrap across the period boundary. phase_int must be less than P.
- R4: When the rising and falling settings are equal in both integer and fraction, `pwm_out` is low for the whole period.
- R5: When fall_int >= period_int, `pwm_out` is high for the whole period.
- R6: Inputs changed during a period do not affect that period. They take effect from the next period on.
- R7: A 6-bit accumulator adds period_frac once per period. When the addition carries, that period is one clock longer. During the extra clock `pwm_out` keeps its previous level. Over any 4 consecutive periods with period_frac = 16 the total length is 4P+1 clocks. Over any 2 consecutive periods with period_frac = 32 it is 2P+1 clocks.
- R8: `rise_tap` equals (((rise_frac + phase_frac) mod 64) * taps_per_clk) >> 6. `fall_tap` is formed the same way from fall_frac.
- R9: Each cycle with `cal_strobe` high changes `taps_per_clk` by one: down when `cal_late` is 1, up when it is 0. The count saturates at 1 and at its maximum. Without a strobe the count holds.
- R10: `cal_locked` is high once the strobe decisions have alternated 8 times in a row. The first decision after reset counts as no alternation. Two equal consecutive decisions clear the lock.
- R11: `cycle_start` is high for exactly the clock in which `pwm_out` shows index k = 0 of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_int | input | 16 | Period, whole clocks (>= 2) |
| period_frac | input | 6 | Period fraction in 1/64 clock |
| rise_int | input | 16 | Rising-edge position, whole clocks |
| rise_frac | input | 6 | Rising-edge fraction |
| fall_int | input | 16 | Falling-edge position, whole clocks |
| fall_frac | input | 6 | Falling-edge fraction |
| phase_int | input | 16 | Phase shift, whole clocks (< period) |
| phase_frac | input | 6 | Phase-shift fraction |
| cal_strobe | input | 1 | One comparison result is valid |
| cal_late | input | 1 | 1: tap count spans more than a clock; 0: less |
| pwm_out | output | 1 | Coarse PWM waveform |
| cycle_start | output | 1 | Marks the first clock of each period |
| rise_tap | output | TAP_W | Delay-line tap code for the rising edge |
| fall_tap | output | TAP_W | Delay-line tap code for the falling edge |
| taps_per_clk | output | TAP_W | Calibrated taps per clock period |
| cal_locked | output | 1 | Calibration loop has settled |

## Verification
Some rules are checked by the bound assertions on every cycle. The tap count holds when there is no strobe and falls by one on a late strobe. Lock can only rise on a cycle that follows a strobe. The period marker never lasts two cycles. A tap code never exceeds the tap count. The waveform's shape can only be shown by the bench's scenarios, because it depends on a whole period of settings: shifted and wrapped windows, carries from the fractions, the empty and full duty cases, and the double buffer. The same holds for the lengths gained from the period fraction, the exact strobe on which lock rises, and its loss.

// File: rtl/hrpwm_pkg.sv
// Shared widths and the split-time type for the hybrid PWM.
// Assumes: fractions are in 1/2**FRAC_W of a clock.
package hrpwm_pkg;
    localparam int INT_W  = 16;
    localparam int FRAC_W = 6;

    // One time setting: whole clocks plus a fraction.
    typedef struct packed {
        logic [INT_W-1:0]  ip;
        logic [FRAC_W-1:0] fp;
    } tset_t;
endpackage

// File: rtl/hrpwm_timebase.sv
// Period counter with shadow registers and a period-fraction accumulator.
// Captures all settings at each period boundary; a carry of the
// accumulator adds one clock to the new period.
// Assumes: period >= 2.
module hrpwm_timebase
    import hrpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tset_t            per_in,
    input  tset_t            rise_in,
    input  tset_t            fall_in,
    input  tset_t            pha_in,
    output tset_t            per_q,
    output tset_t            rise_q,
    output tset_t            fall_q,
    output tset_t            pha_q,
    output logic [INT_W-1:0] cnt_q,
    output logic             ext_q,
    output logic             live_q
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic [INT_W:0]    end_cnt;
    logic              load;

    // Next accumulator value, final count of this period, load decision.
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, per_in.fp};
        end_cnt = {1'b0, per_q.ip} - {{INT_W{1'b0}}, 1'b1} + {{INT_W{1'b0}}, ext_q};
        load    = !live_q || ({1'b0, cnt_q} == end_cnt);
    end

    // Count within the period; reload shadows at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            pha_q  <= '0;
            acc_q  <= '0;
            ext_q  <= 1'b0;
            cnt_q  <= '0;
            live_q <= 1'b0;
        end else if (load) begin
            per_q  <= per_in;
            rise_q <= rise_in;
            fall_q <= fall_in;
            pha_q  <= pha_in;
            acc_q  <= acc_sum[FRAC_W-1:0];
            ext_q  <= acc_sum[FRAC_W];
            cnt_q  <= '0;
            live_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hrpwm_edge.sv
// Coarse comparator: forms the phase-shifted index and the edge positions
// (with fraction carries) and registers the waveform and period marker.
// Assumes: phase integer < period.
module hrpwm_edge
    import hrpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tset_t            per_q,
    input  tset_t            rise_q,
    input  tset_t            fall_q,
    input  tset_t            pha_q,
    input  logic [INT_W-1:0] cnt_q,
    input  logic             ext_q,
    input  logic             live_q,
    output logic             pwm_out,
    output logic             cycle_start
);
    logic [INT_W:0]  cnt_w, pha_w, per_w, s_idx, rise_pos, fall_pos;
    logic [FRAC_W:0] rsum, fsum;
    logic            in_extra, empty, full, win;

    // Shifted index, edge positions and the special duty cases.
    always_comb begin
        cnt_w    = {1'b0, cnt_q};
        pha_w    = {1'b0, pha_q.ip};
        per_w    = {1'b0, per_q.ip};
        s_idx    = (cnt_w >= pha_w) ? (cnt_w - pha_w) : (cnt_w + per_w - pha_w);
        rsum     = {1'b0, rise_q.fp} + {1'b0, pha_q.fp};
        fsum     = {1'b0, fall_q.fp} + {1'b0, pha_q.fp};
        rise_pos = {1'b0, rise_q.ip} + {{INT_W{1'b0}}, rsum[FRAC_W]};
        fall_pos = {1'b0, fall_q.ip} + {{INT_W{1'b0}}, fsum[FRAC_W]};
        in_extra = ext_q && (cnt_q == per_q.ip);
        empty    = (rise_q == fall_q);
        full     = (fall_q.ip >= per_q.ip);
        win      = (s_idx >= rise_pos) && (s_idx < fall_pos);
    end

    // Register the waveform level and the period marker.
    always_ff @(posedge clk) begin
        if (!rst_n || !live_q) begin
            pwm_out     <= 1'b0;
            cycle_start <= 1'b0;
        end else begin
            cycle_start <= (cnt_q == '0);
            if (in_extra)   pwm_out <= pwm_out;
            else if (full)  pwm_out <= 1'b1;
            else if (empty) pwm_out <= 1'b0;
            else            pwm_out <= win;
        end
    end
endmodule

// File: rtl/hrpwm_fine.sv
// Fine stage: scales each edge fraction (plus phase fraction, mod one
// clock) by the calibrated taps per clock to give a delay-line tap code.
// Assumes: tap codes are consumed by an external delay line.
module hrpwm_fine
    import hrpwm_pkg::*;
#(
    parameter int TAP_W  = 8,
    parameter int EDGE_N = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [EDGE_N-1:0][FRAC_W-1:0] edge_frac,
    input  logic [FRAC_W-1:0]             pha_frac,
    input  logic [TAP_W-1:0]              taps,
    output logic [EDGE_N-1:0][TAP_W-1:0]  tap_code
);
    localparam int PROD_W = FRAC_W + TAP_W;

    for (genvar e = 0; e < EDGE_N; e++) begin : g_edge
        logic [FRAC_W-1:0] frac_sum;
        logic [PROD_W-1:0] prod;

        // Fraction with phase added, times taps per clock.
        always_comb begin
            frac_sum = edge_frac[e] + pha_frac;
            prod     = PROD_W'(frac_sum) * PROD_W'(taps);
        end

        // Register the tap code for this edge.
        always_ff @(posedge clk) begin
            if (!rst_n) tap_code[e] <= '0;
            else        tap_code[e] <= prod[PROD_W-1:FRAC_W];
        end
    end
endmodule

// File: rtl/hrpwm_cal.sv
// Delay-locked calibration loop: steps the taps-per-clock count by one per
// early/late comparison and reports lock after LOCK_N alternations.
// Assumes: cal_late is valid whenever cal_strobe is high.
module hrpwm_cal #(
    parameter int TAP_W     = 8,
    parameter int TAPS_INIT = 32,
    parameter int LOCK_N    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_strobe,
    input  logic             cal_late,
    output logic [TAP_W-1:0] taps_q,
    output logic             locked
);
    localparam int AC_W = $clog2(LOCK_N + 1);
    localparam logic [TAP_W-1:0] TAP_MAX = '1;
    localparam logic [AC_W-1:0]  ALT_TOP = AC_W'(LOCK_N);

    logic            prev_dec, have_prev;
    logic [AC_W-1:0] alt_q;

    // Step the tap count and track alternating decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps_q    <= TAP_W'(TAPS_INIT);
            prev_dec  <= 1'b0;
            have_prev <= 1'b0;
            alt_q     <= '0;
        end else if (cal_strobe) begin
            if (cal_late && taps_q > 1)             taps_q <= taps_q - 1'b1;
            else if (!cal_late && taps_q < TAP_MAX) taps_q <= taps_q + 1'b1;
            prev_dec  <= cal_late;
            have_prev <= 1'b1;
            if (have_prev && (cal_late != prev_dec))
                alt_q <= (alt_q == ALT_TOP) ? alt_q : alt_q + 1'b1;
            else
                alt_q <= '0;
        end
    end

    // Lock once enough alternations have been seen.
    always_comb locked = (alt_q >= ALT_TOP);
endmodule

// File: rtl/hrpwm_gen.sv
// Top of the hybrid high-resolution PWM: timebase, coarse edge logic,
// fine tap scaling and the calibration loop.
// Assumes: period_int >= 2, phase_int < period_int.
module hrpwm_gen
    import hrpwm_pkg::*;
#(
    parameter int TAP_W     = 8,
    parameter int TAPS_INIT = 32,
    parameter int LOCK_N    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       period_int,
    input  logic [5:0]        period_frac,
    input  logic [15:0]       rise_int,
    input  logic [5:0]        rise_frac,
    input  logic [15:0]       fall_int,
    input  logic [5:0]        fall_frac,
    input  logic [15:0]       phase_int,
    input  logic [5:0]        phase_frac,
    input  logic              cal_strobe,
    input  logic              cal_late,
    output logic              pwm_out,
    output logic              cycle_start,
    output logic [TAP_W-1:0]  rise_tap,
    output logic [TAP_W-1:0]  fall_tap,
    output logic [TAP_W-1:0]  taps_per_clk,
    output logic              cal_locked
);
    tset_t per_in, rise_in, fall_in, pha_in;
    tset_t per_q, rise_q, fall_q, pha_q;
    logic [INT_W-1:0] cnt_q;
    logic             ext_q, live_q;
    logic [1:0][FRAC_W-1:0] efrac;
    logic [1:0][TAP_W-1:0]  codes;

    // Pack the port fields into setting structs.
    always_comb begin
        per_in   = '{ip: period_int, fp: period_frac};
        rise_in  = '{ip: rise_int,   fp: rise_frac};
        fall_in  = '{ip: fall_int,   fp: fall_frac};
        pha_in   = '{ip: phase_int,  fp: phase_frac};
        efrac[0] = rise_q.fp;
        efrac[1] = fall_q.fp;
        rise_tap = codes[0];
        fall_tap = codes[1];
    end

    hrpwm_timebase u_tb (
        .clk(clk), .rst_n(rst_n),
        .per_in(per_in), .rise_in(rise_in), .fall_in(fall_in), .pha_in(pha_in),
        .per_q(per_q), .rise_q(rise_q), .fall_q(fall_q), .pha_q(pha_q),
        .cnt_q(cnt_q), .ext_q(ext_q), .live_q(live_q)
    );

    hrpwm_edge u_edge (
        .clk(clk), .rst_n(rst_n),
        .per_q(per_q), .rise_q(rise_q), .fall_q(fall_q), .pha_q(pha_q),
        .cnt_q(cnt_q), .ext_q(ext_q), .live_q(live_q),
        .pwm_out(pwm_out), .cycle_start(cycle_start)
    );

    hrpwm_fine #(.TAP_W(TAP_W), .EDGE_N(2)) u_fine (
        .clk(clk), .rst_n(rst_n),
        .edge_frac(efrac), .pha_frac(pha_q.fp),
        .taps(taps_per_clk), .tap_code(codes)
    );

    hrpwm_cal #(.TAP_W(TAP_W), .TAPS_INIT(TAPS_INIT), .LOCK_N(LOCK_N)) u_cal (
        .clk(clk), .rst_n(rst_n),
        .cal_strobe(cal_strobe), .cal_late(cal_late),
        .taps_q(taps_per_clk), .locked(cal_locked)
    );
endmodule

// File: rtl/hrpwm_gen_chk.sv
// Cycle-by-cycle properties of the hybrid PWM, bound to the top module.
module hrpwm_gen_chk #(
    parameter int TAP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cal_strobe,
    input logic             cal_late,
    input logic             cycle_start,
    input logic [TAP_W-1:0] rise_tap,
    input logic [TAP_W-1:0] fall_tap,
    input logic [TAP_W-1:0] taps_per_clk,
    input logic             cal_locked
);
    assert_taps_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_strobe |=> $stable(taps_per_clk));

    assert_taps_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_strobe && cal_late && taps_per_clk > 1) |=>
        (taps_per_clk == $past(taps_per_clk) - 1'b1));

    assert_lock_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_locked) |-> $past(cal_strobe));

    assert_single_marker_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);

    assert_tap_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_tap <= taps_per_clk) && (fall_tap <= taps_per_clk));
endmodule

bind hrpwm_gen hrpwm_gen_chk #(.TAP_W(TAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cal_strobe(cal_strobe), .cal_late(cal_late),
    .cycle_start(cycle_start), .rise_tap(rise_tap), .fall_tap(fall_tap),
    .taps_per_clk(taps_per_clk), .cal_locked(cal_locked)
);

// File: tb/tb_hrpwm_gen.sv
`timescale 1ns/1ps
module tb_hrpwm_gen;
    localparam int TAP_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] period_int = 16'd10, rise_int = '0, fall_int = '0, phase_int = '0;
    logic [5:0]  period_frac = '0, rise_frac = '0, fall_frac = '0, phase_frac = '0;
    logic cal_strobe = 1'b0, cal_late = 1'b0;
    logic pwm_out, cycle_start, cal_locked;
    logic [TAP_W-1:0] rise_tap, fall_tap, taps_per_clk;

    int checks = 0;
    int errors = 0;
    bit exp_q[$];
    string req_q[$];

    always #2.5 clk = ~clk;

    hrpwm_gen #(.TAP_W(TAP_W), .TAPS_INIT(32), .LOCK_N(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .period_int(period_int), .period_frac(period_frac),
        .rise_int(rise_int), .rise_frac(rise_frac),
        .fall_int(fall_int), .fall_frac(fall_frac),
        .phase_int(phase_int), .phase_frac(phase_frac),
        .cal_strobe(cal_strobe), .cal_late(cal_late),
        .pwm_out(pwm_out), .cycle_start(cycle_start),
        .rise_tap(rise_tap), .fall_tap(fall_tap),
        .taps_per_clk(taps_per_clk), .cal_locked(cal_locked)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops one expected level per clock and compares.
    always @(negedge clk) begin
        #0.5;
        if (exp_q.size() > 0) check(req_q.pop_front(), int'(pwm_out), int'(exp_q.pop_front()));
    end

    task automatic wait_start();
        do @(negedge clk); while (!cycle_start);
    endtask

    task automatic set_cfg(input int p, input int pf, input int r, input int rf,
                           input int f, input int ff, input int ph, input int phf);
        period_int = 16'(p); period_frac = 6'(pf);
        rise_int = 16'(r); rise_frac = 6'(rf);
        fall_int = 16'(f); fall_frac = 6'(ff);
        phase_int = 16'(ph); phase_frac = 6'(phf);
    endtask

    // Driver: pushes a full period of expected levels from the rules.
    task automatic push_period(input int p, input int r, input int rf, input int f,
                               input int ff, input int ph, input int phf, input string req);
        int rp = r + ((rf + phf) >= 64 ? 1 : 0);
        int fp = f + ((ff + phf) >= 64 ? 1 : 0);
        for (int k = 0; k < p; k++) begin
            int s = (k - ph + p) % p;
            bit b;
            if (f >= p) b = 1'b1;
            else if (r == f && rf == ff) b = 1'b0;
            else b = (s >= rp) && (s < fp);
            exp_q.push_back(b);
            req_q.push_back(req);
        end
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic run_case(input int p, input int r, input int rf, input int f,
                            input int ff, input int ph, input int phf, input string req);
        set_cfg(p, 0, r, rf, f, ff, ph, phf);
        wait_start();
        wait_start();
        push_period(p, r, rf, f, ff, ph, phf, req);
        drain();
    endtask

    task automatic strobe(input bit late);
        cal_strobe = 1'b1; cal_late = late;
        @(negedge clk);
        cal_strobe = 1'b0;
    endtask

    task automatic measure(input int n, input int exp, input string req);
        int cyc = 0;
        int seen = 0;
        wait_start();
        while (seen < n) begin
            @(negedge clk);
            cyc++;
            if (cycle_start) seen++;
        end
        check(req, cyc, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 pwm", pwm_out, 0);
        check("R1 start", cycle_start, 0);
        check("R1 lock", cal_locked, 0);
        check("R1 taps", taps_per_clk, 32);
        check("R1 rtap", rise_tap, 0);
        check("R1 ftap", fall_tap, 0);
        rst_n = 1'b1;

        // R9 / R10 calibration against a line of 40 taps per clock
        for (int i = 1; i <= 17; i++) begin
            strobe(taps_per_clk > 40);
            if (i == 1) check("R9 step up", taps_per_clk, 33);
            if (i == 16) check("R10 not yet locked", cal_locked, 0);
        end
        check("R10 locked", cal_locked, 1);
        check("R9 taps at lock", taps_per_clk, 41);
        strobe(1'b1);
        check("R9 step down", taps_per_clk, 40);
        check("R10 still locked", cal_locked, 1);
        strobe(1'b1);
        check("R10 lock cleared", cal_locked, 0);
        check("R9 taps", taps_per_clk, 39);
        repeat (3) @(negedge clk);
        check("R9 hold", taps_per_clk, 39);

        // R11 marker against a plain period, R2 waveforms
        run_case(10, 2, 0, 6, 0, 0, 0, "R2 basic");
        run_case(10, 0, 0, 1, 0, 0, 0, "R2 narrow");
        run_case(10, 3, 5, 7, 9, 3, 0, "R3 shift");
        run_case(10, 6, 0, 9, 0, 3, 0, "R3 wrap");
        run_case(10, 2, 40, 6, 0, 0, 40, "R3 carry");
        check("R8 rise tap", rise_tap, (16 * 39) >> 6);
        check("R8 fall tap", fall_tap, (40 * 39) >> 6);
        run_case(10, 4, 8, 4, 8, 0, 0, "R4 empty");
        run_case(10, 2, 0, 12, 0, 0, 0, "R5 full");
        run_case(12, 0, 0, 12, 0, 5, 0, "R5 full at period");

        // R6 double buffer: change mid-period, old pattern must hold
        run_case(10, 2, 0, 6, 0, 0, 0, "R6 before");
        wait_start();
        push_period(10, 2, 0, 6, 0, 0, 0, "R6 old kept");
        @(negedge clk);
        set_cfg(10, 0, 1, 0, 8, 0, 0, 0);
        drain();
        push_period(10, 1, 0, 8, 0, 0, 0, "R6 new applied");
        drain();

        // R11 marker spacing, R7 fractional period
        set_cfg(10, 0, 2, 0, 6, 0, 0, 0);
        wait_start();
        measure(1, 10, "R11 spacing");
        set_cfg(10, 16, 2, 0, 6, 0, 0, 0);
        wait_start();
        measure(4, 41, "R7 frac 16");
        set_cfg(10, 32, 2, 0, 6, 0, 0, 0);
        wait_start();
        measure(2, 21, "R7 frac 32");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule